// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide flash bank made of 32 equal sectors. It watches single-cycle write strobes that each carry an address and a data byte. It recognises keyed unlock sequences that lead to one of three operations:

- programming a single byte,
- erasing one or more chosen sectors,
- erasing the whole array.

It then runs a timed embedded operation whose length is set in clock cycles. The array is a small synthesizable memory; each sector holds only a few bytes.

While an operation runs, the block raises a busy flag. Every read during that time returns a polled status byte instead of array data, so a host can detect completion either by data polling or by watching a toggling bit. When idle, a read returns the addressed byte one cycle after the read strobe. The reset input returns the command interpreter to plain read mode at once and leaves the array as it was.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While rstN is low, busy is low and the decoder is in read mode. A reset during a running operation drops busy at once, and the pending change never reaches the array. A reset in the middle of an unlock sequence discards the keys already given.
- R2: The writes AAh to 5555h, 55h to 2AAAh and A0h to 5555h, followed by a fourth write of address A and data D, program byte A to (old value AND D).
- R3: busy rises in the cycle after the fourth program write and stays high for exactly PROG_CYCLES cycles.
- R4: A read during programming returns a status byte:
  - bit 7 is the complement of bit 7 of the data being programmed;
  - bit 6 is 0 on the first read of the operation and inverts on every later read;
  - bits 5..0 are 0.
  After completion, reads return the true array data.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, then 30h written to any address of a sector, erase that sector to FFh and leave every other sector unchanged. In the array address, the low log2(SECTOR_BYTES) bits select the byte and the bits above them select the sector. busy then stays high for ERASE_WIN_CYCLES + SECTOR_CYCLES cycles.
- R6: During the sector-select window, each further 30h write adds its sector and restarts the window. A write of any other byte during the window is ignored.
- R7: The same five unlock writes followed by 10h written to 5555h erase every byte to FFh, with busy high for exactly CHIP_CYCLES cycles.
- R8: Any write that does not match the next expected key (wrong data or wrong address) returns the decoder to read mode. Such a write starts no operation and leaves the array unchanged.
- R9: Only address bits 14..0 are compared for the 5555h and 2AAAh keys; higher address bits are ignored.
- R10: Writes made while busy is high start nothing and change nothing.
- R11: When not busy, a read returns the addressed array byte on rdData one clock after the cycle in which rdEn is high.
- R12: A read during an erase returns a status byte with bit 7 = 0, bit 6 toggling as in R4, and bits 5..0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset to read mode |
| wrEn | input | 1 | Write strobe, one cycle per bus write |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrData | input | 8 | Write data / command byte |
| rdData | output | 8 | Array byte or status byte, registered |
| busy | output | 1 | High while an embedded operation runs |

## Verification
A corrupted sequence state shows up as one of two symptoms. Either a well-formed command produces no busy pulse in the cycle after its last write, or a malformed one produces a busy pulse; both are visible within one clock. A wrong operation timer shows up as a busy pulse whose length differs from the configured cycle count. A wrong sector mask or a wrong program latch appears only after busy falls, as array bytes that differ from the expected AND or FFh values. For that reason the whole array is read back after each kind of operation. A stuck toggle register appears on the second status read of an operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNLK1,
    ST_UNLK2,
    ST_PROGARM,
    ST_ERS3,
    ST_ERS4,
    ST_ERS5,
    ST_WINDOW,
    ST_PROGRUN,
    ST_ERASERUN
  } seqState_t;

  typedef struct packed {
    logic latchProg;
    logic commitProg;
    logic markSector;
    logic markAll;
    logic commitErase;
    logic showStatus;
    logic opIsProg;
    logic toggleVal;
  } dpStrobes_t;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECTOR = 8'h30;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES      = 16,
  parameter int SECTOR_CYCLES    = 64,
  parameter int CHIP_CYCLES      = 256,
  parameter int ERASE_WIN_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [14:0] keyAddr,
  input  logic [7:0]  wrData,
  output logic        busy,
  output dpStrobes_t  stb
);

  localparam int MAX_PS  = (PROG_CYCLES > SECTOR_CYCLES) ? PROG_CYCLES : SECTOR_CYCLES;
  localparam int MAX_CW  = (CHIP_CYCLES > ERASE_WIN_CYCLES) ? CHIP_CYCLES : ERASE_WIN_CYCLES;
  localparam int MAX_DUR = (MAX_PS > MAX_CW) ? MAX_PS : MAX_CW;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SECT_LOAD = CNT_W'(SECTOR_CYCLES - 1);
  localparam logic [CNT_W-1:0] CHIP_LOAD = CNT_W'(CHIP_CYCLES - 1);
  localparam logic [CNT_W-1:0] WIN_LOAD  = CNT_W'(ERASE_WIN_CYCLES - 1);

  initial begin
    if (PROG_CYCLES < 1 || SECTOR_CYCLES < 1 || CHIP_CYCLES < 1 || ERASE_WIN_CYCLES < 1)
      $error("flash_cmd_ctrl: every duration must be at least one cycle");
  end

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             toggle;
  logic             startOp;
  logic             isKeyA, isKeyB;

  assign isKeyA = (keyAddr == KEY_ADDR_A);
  assign isKeyB = (keyAddr == KEY_ADDR_B);
  assign busy   = (state == ST_WINDOW) || (state == ST_PROGRUN) || (state == ST_ERASERUN);

  always_comb begin
    stateNxt        = state;
    cntNxt          = cnt;
    startOp         = 1'b0;
    stb             = '0;
    stb.showStatus  = busy;
    stb.opIsProg    = (state == ST_PROGRUN);
    stb.toggleVal   = toggle;
    unique case (state)
      ST_READ: begin
        if (wrEn && isKeyA && wrData == KEY_FIRST) stateNxt = ST_UNLK1;
      end
      ST_UNLK1: begin
        if (wrEn) stateNxt = (isKeyB && wrData == KEY_SECOND) ? ST_UNLK2 : ST_READ;
      end
      ST_UNLK2: begin
        if (wrEn) begin
          if (isKeyA && wrData == CMD_PROG)       stateNxt = ST_PROGARM;
          else if (isKeyA && wrData == CMD_ERASE) stateNxt = ST_ERS3;
          else                                    stateNxt = ST_READ;
        end
      end
      ST_PROGARM: begin
        if (wrEn) begin
          stb.latchProg = 1'b1;
          startOp       = 1'b1;
          cntNxt        = PROG_LOAD;
          stateNxt      = ST_PROGRUN;
        end
      end
      ST_ERS3: begin
        if (wrEn) stateNxt = (isKeyA && wrData == KEY_FIRST) ? ST_ERS4 : ST_READ;
      end
      ST_ERS4: begin
        if (wrEn) stateNxt = (isKeyB && wrData == KEY_SECOND) ? ST_ERS5 : ST_READ;
      end
      ST_ERS5: begin
        if (wrEn) begin
          if (isKeyA && wrData == CMD_CHIP) begin
            stb.markAll = 1'b1;
            startOp     = 1'b1;
            cntNxt      = CHIP_LOAD;
            stateNxt    = ST_ERASERUN;
          end else if (wrData == CMD_SECTOR) begin
            stb.markSector = 1'b1;
            startOp        = 1'b1;
            cntNxt         = WIN_LOAD;
            stateNxt       = ST_WINDOW;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      ST_WINDOW: begin
        if (wrEn && wrData == CMD_SECTOR) begin
          stb.markSector = 1'b1;
          cntNxt         = WIN_LOAD;
        end else if (cnt == '0) begin
          cntNxt   = SECT_LOAD;
          stateNxt = ST_ERASERUN;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_PROGRUN: begin
        if (cnt == '0) begin
          stb.commitProg = 1'b1;
          stateNxt       = ST_READ;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_ERASERUN: begin
        if (cnt == '0) begin
          stb.commitErase = 1'b1;
          stateNxt        = ST_READ;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      default: stateNxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_READ;
      cnt    <= '0;
      toggle <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (startOp)          toggle <= 1'b0;
      else if (busy && rdEn) toggle <= ~toggle;
    end
  end

  p_commit_ends_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitProg || stb.commitErase) |=> !busy);

  p_prog_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROGARM && wrEn) |=> (busy && state == ST_PROGRUN));

  p_toggle_flips_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdEn) |=> (toggle != $past(toggle)));

  p_busy_ignores_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROGRUN && wrEn && cnt != '0) |=> (state == ST_PROGRUN));

  p_bad_key_aborts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UNLK1 && wrEn && wrData != KEY_SECOND) |=> (state == ST_READ));

  p_commit_needs_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitProg || stb.commitErase) |-> busy);

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int NUM_SECTORS  = 32,
  parameter int SECTOR_BYTES = 4,
  parameter int ADDR_W       = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  localparam int SEC_AW = $clog2(SECTOR_BYTES);
  localparam int SEC_IW = $clog2(NUM_SECTORS);
  localparam int MEM_AW = SEC_AW + SEC_IW;
  localparam int ROW_W  = 8 * SECTOR_BYTES;

  initial begin
    if (SECTOR_BYTES < 2 || (1 << SEC_AW) != SECTOR_BYTES || (1 << SEC_IW) != NUM_SECTORS)
      $error("flash_cmd_dp: sector size and count must be powers of two, size at least 2");
    if (ADDR_W < 15 || ADDR_W < MEM_AW)
      $error("flash_cmd_dp: address too narrow for keys or array");
  end

  logic [NUM_SECTORS-1:0] eraseMask;
  logic [MEM_AW-1:0]      progAddr;
  logic [7:0]             progData;
  logic [ROW_W-1:0]       secView [NUM_SECTORS];

  logic [SEC_IW-1:0] curSec;
  logic [SEC_AW-1:0] curOff;
  logic [7:0]        arrayByte;
  logic [7:0]        statusByte;

  assign curSec = addr[MEM_AW-1:SEC_AW];
  assign curOff = addr[SEC_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseMask <= '0;
      progAddr  <= '0;
      progData  <= '0;
    end else begin
      if (stb.latchProg) begin
        progAddr <= addr[MEM_AW-1:0];
        progData <= wrData;
      end
      if (stb.commitErase)     eraseMask <= '0;
      else if (stb.markAll)    eraseMask <= '1;
      else if (stb.markSector) eraseMask[curSec] <= 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    logic [ROW_W-1:0] cells;
    logic             progHere;
    assign progHere = stb.commitProg && (progAddr[MEM_AW-1:SEC_AW] == SEC_IW'(s));
    always_ff @(posedge clk) begin
      for (int b = 0; b < SECTOR_BYTES; b++) begin
        if (stb.commitErase && eraseMask[s])
          cells[b*8 +: 8] <= 8'hFF;
        else if (progHere && progAddr[SEC_AW-1:0] == SEC_AW'(b))
          cells[b*8 +: 8] <= cells[b*8 +: 8] & progData;
      end
    end
    assign secView[s] = cells;
  end

  assign arrayByte  = secView[curSec][{curOff, 3'b000} +: 8];
  assign statusByte = {stb.opIsProg ? ~progData[7] : 1'b0, stb.toggleVal, 6'b000000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= stb.showStatus ? statusByte : arrayByte;
  end

  p_prog_poll_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stb.showStatus && stb.opIsProg) |=> (rdData[7] == ~progData[7] && rdData[5:0] == 6'b0));

  p_erase_poll_bits_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stb.showStatus && !stb.opIsProg) |=> (rdData[7] == 1'b0 && rdData[5:0] == 6'b0));

  p_mask_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitErase |=> (eraseMask == '0));

  p_chip_mask_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.markAll && !stb.commitErase) |=> (&eraseMask));

  p_sector_added_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.markSector && !stb.commitErase) |=> eraseMask[$past(curSec)]);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int NUM_SECTORS      = 32,
  parameter int SECTOR_BYTES     = 4,
  parameter int ADDR_W           = 21,
  parameter int PROG_CYCLES      = 16,
  parameter int SECTOR_CYCLES    = 64,
  parameter int CHIP_CYCLES      = 256,
  parameter int ERASE_WIN_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              busy
);

  dpStrobes_t stb;

  flash_cmd_ctrl #(
    .PROG_CYCLES     (PROG_CYCLES),
    .SECTOR_CYCLES   (SECTOR_CYCLES),
    .CHIP_CYCLES     (CHIP_CYCLES),
    .ERASE_WIN_CYCLES(ERASE_WIN_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .keyAddr(addr[14:0]),
    .wrData (wrData),
    .busy   (busy),
    .stb    (stb)
  );

  flash_cmd_dp #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECTOR_BYTES(SECTOR_BYTES),
    .ADDR_W      (ADDR_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rdEn  (rdEn),
    .addr  (addr),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSEC  = 32;
  localparam int SBYT  = 4;
  localparam int NBYTE = NSEC * SBYT;
  localparam int AW    = 21;
  localparam int PROG  = 10;
  localparam int SECT  = 16;
  localparam int CHIP  = 24;
  localparam int WIN   = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdData;
  logic          busy;

  int  nCompared = 0;
  int  nMismatch = 0;
  bit  finished  = 1'b0;
  logic [7:0] expMem [NBYTE];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(
    .NUM_SECTORS(NSEC), .SECTOR_BYTES(SBYT), .ADDR_W(AW),
    .PROG_CYCLES(PROG), .SECTOR_CYCLES(SECT), .CHIP_CYCLES(CHIP), .ERASE_WIN_CYCLES(WIN)
  ) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 21'h5555, 8'hAA);
    wr(hi | 21'h2AAA, 8'h55);
  endtask

  task automatic progCmd(input logic [AW-1:0] hi, input int idx, input logic [7:0] d);
    unlock(hi);
    wr(hi | 21'h5555, 8'hA0);
    wr(hi | AW'(idx), d);
  endtask

  task automatic eraseKeys();
    unlock('0);
    wr(21'h5555, 8'h80);
    unlock('0);
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int i = 0; i < NBYTE; i++) begin
      rd(AW'(i), v);
      check(v == expMem[i], req, v, expMem[i]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [7:0] v;
    logic [7:0] d;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);

    // R7 chip erase and its length
    eraseKeys();
    wr(21'h5555, 8'h10);
    countBusy(n);
    check(n == CHIP, "R7 chip erase busy length", n, CHIP);
    for (int i = 0; i < NBYTE; i++) expMem[i] = 8'hFF;
    sweep("R7 chip erase contents");

    // R2/R9/R11 program every byte, alternating upper address bits on keys
    for (int i = 0; i < NBYTE; i++) begin
      d = 8'((i * 37 + 5) & 8'hFF);
      progCmd((i % 2 == 1) ? 21'h18000 : 21'h0, i, d);
      countBusy(n);
      if (i < 4) check(n == PROG, "R3 program busy length", n, PROG);
      expMem[i] = expMem[i] & d;
    end
    sweep("R2 R9 R11 programmed contents");

    // R2 second program only clears bits
    progCmd('0, 3, 8'hF0);
    countBusy(n);
    expMem[3] = expMem[3] & 8'hF0;
    rd(21'd3, v);
    check(v == expMem[3], "R2 and-program", v, expMem[3]);

    // R4 status during program, bit7 of data = 1 then = 0
    progCmd('0, 10, 8'h80);
    rd(21'd10, v);
    check(v == 8'h00, "R4 first poll d7=1", v, 8'h00);
    rd(21'd10, v);
    check(v == 8'h40, "R4 second poll d7=1", v, 8'h40);
    countBusy(n);
    expMem[10] = expMem[10] & 8'h80;
    rd(21'd10, v);
    check(v == expMem[10], "R4 true data after program", v, expMem[10]);
    progCmd('0, 11, 8'h00);
    rd(21'd11, v);
    check(v == 8'h80, "R4 first poll d7=0", v, 8'h80);
    rd(21'd11, v);
    check(v == 8'hC0, "R4 second poll d7=0", v, 8'hC0);
    rd(21'd11, v);
    check(v == 8'h80, "R4 third poll d7=0", v, 8'h80);
    countBusy(n);
    expMem[11] = 8'h00;

    // R5 single sector erase and its length
    eraseKeys();
    wr(21'(5 * SBYT + 1), 8'h30);
    countBusy(n);
    check(n == WIN + SECT, "R5 sector erase busy length", n, WIN + SECT);
    for (int b = 0; b < SBYT; b++) expMem[5 * SBYT + b] = 8'hFF;
    sweep("R5 sector erase contents");

    // R6 multi-sector window, R12 erase status
    eraseKeys();
    wr(21'(7 * SBYT), 8'h30);
    wr(21'(9 * SBYT + 2), 8'h30);
    wr(21'(11 * SBYT), 8'h20);
    rd(21'd0, v);
    check(v == 8'h00, "R12 first erase poll", v, 8'h00);
    rd(21'd0, v);
    check(v == 8'h40, "R12 second erase poll", v, 8'h40);
    countBusy(n);
    for (int b = 0; b < SBYT; b++) begin
      expMem[7 * SBYT + b] = 8'hFF;
      expMem[9 * SBYT + b] = 8'hFF;
    end
    sweep("R6 multi-sector contents");

    // R8 broken sequences
    wr(21'h5555, 8'hAA);
    wr(21'h2AAB, 8'h55);
    wr(21'h5555, 8'hA0);
    wr(21'd0, 8'h00);
    @(negedge clk);
    check(busy == 1'b0, "R8 bad address no busy", busy, 0);
    rd(21'd0, v);
    check(v == expMem[0], "R8 bad address array unchanged", v, expMem[0]);
    eraseKeys();
    wr(21'h1234, 8'h10);
    @(negedge clk);
    check(busy == 1'b0, "R8 chip code off key no busy", busy, 0);
    rd(21'h34, v);
    check(v == expMem[8'h34], "R8 no erase", v, expMem[8'h34]);
    unlock('0);
    wr(21'h5555, 8'h77);
    wr(21'd1, 8'h00);
    @(negedge clk);
    check(busy == 1'b0, "R8 bad command no busy", busy, 0);
    progCmd('0, 1, 8'h00);
    countBusy(n);
    check(n == PROG, "R8 recovery program", n, PROG);
    expMem[1] = 8'h00;
    rd(21'd1, v);
    check(v == 8'h00, "R8 recovery data", v, 0);

    // R10 writes during busy
    progCmd('0, 20, 8'h0F);
    progCmd('0, 21, 8'h00);
    countBusy(n);
    expMem[20] = expMem[20] & 8'h0F;
    rd(21'd21, v);
    check(v == expMem[21], "R10 busy write ignored", v, expMem[21]);
    rd(21'd20, v);
    check(v == expMem[20], "R10 running program completes", v, expMem[20]);

    // R1 reset mid-operation and mid-sequence
    progCmd('0, 30, 8'h00);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(busy == 1'b0, "R1 reset drops busy", busy, 0);
    @(negedge clk);
    rstN = 1'b1;
    rd(21'd30, v);
    check(v == expMem[30], "R1 aborted program", v, expMem[30]);
    unlock('0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    wr(21'h5555, 8'hA0);
    wr(21'd31, 8'h00);
    @(negedge clk);
    check(busy == 1'b0, "R1 keys discarded", busy, 0);
    rd(21'd31, v);
    check(v == expMem[31], "R1 keys discarded data", v, expMem[31]);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule